// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two 16-bit buses, called A and B, through two 8-bit lanes that work independently of each other. Each lane can drive one of its two ports at a time. The driven port carries either the live value of the opposite port or a stored copy of it. Each lane has one capture register per port. The register for the A port loads on a rising edge of its capture strobe, and the register for the B port loads on a rising edge of its own strobe. Capture happens whatever the lane's enable and direction inputs are doing.

Every bus pin is modelled as three signals: an external input, an output value and a drive flag. Tri-state wiring stays outside the block, which keeps the block synthesizable. A keeper register holds the last level that each port drove. When the port stops driving, its output keeps that level instead of floating. The capture strobes are sampled on the single system clock, and the block detects their rising edges itself.

Top module: `bidir_xcvr16`

## Requirements
- R1: Lanes are independent. Lane k uses bits [8k+7:8k] of every bus and bit k of every control vector, and nothing in one lane changes the drive flags, outputs or stored data of the other lane.
- R2: When a lane's `oe_n` is 1, the lane is isolated: its `a_drv` and `b_drv` bits are both 0.
- R3: When `oe_n`=0 and `dir`=0, only the A port of the lane is driven. With `sel_ba`=0, `a_out` equals the live `b_in` in the same cycle.
- R4: When `oe_n`=0, `dir`=0 and `sel_ba`=1, `a_out` shows the lane's stored B register.
- R5: When `oe_n`=0 and `dir`=1, only the B port of the lane is driven. With `sel_ab`=0, `b_out` equals the live `a_in` in the same cycle.
- R6: When `oe_n`=0, `dir`=1 and `sel_ab`=1, `b_out` shows the lane's stored A register.
- R7: In the first clock cycle that `cap_a` (or `cap_b`) is sampled high after being low, the A (or B) register loads the value of its port, and that value is visible from the next cycle on. The register does not load again while the strobe stays high or when it falls.
- R8: Capture works whatever `oe_n` and `dir` are, including while the lane is isolated.
- R9: The select input of the direction that is not driven has no effect on the drive flags or on the driven value.
- R10: While a port is not driven, its output keeps the last value it drove, and a change on the external inputs does not alter it.
- R11: The value a port presents for capture is its external input when the port is not driven, and its own driven output when it is.
- R12: A synchronous reset (`rst_n`=0 at a clock edge) clears both capture registers and both keeper registers in each lane to 0.
- R13: In any cycle, a lane never drives both its A port and its B port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| oe_n | input | 2 | Per-lane active-low output enable |
| dir | input | 2 | Per-lane direction: 0 drives A, 1 drives B |
| sel_ab | input | 2 | Per-lane source for B output: 0 live A, 1 stored A |
| sel_ba | input | 2 | Per-lane source for A output: 0 live B, 1 stored B |
| cap_a | input | 2 | Per-lane strobe that loads the A register on its rising edge |
| cap_b | input | 2 | Per-lane strobe that loads the B register on its rising edge |
| a_in | input | 16 | External value on the A bus |
| a_out | output | 16 | Value driven, or kept, on the A bus |
| a_drv | output | 2 | Per-lane A bus drive flag |
| b_in | input | 16 | External value on the B bus |
| b_out | output | 16 | Value driven, or kept, on the B bus |
| b_drv | output | 2 | Per-lane B bus drive flag |

## Verification
The bench holds a capture strobe high for more than one cycle and changes the port value while it is still high. A design that loads on the strobe level instead of its edge would then store the later value. It captures while the lane is isolated, and it captures on a port the lane is driving with an external value that differs from the driven one. A design that ignored the drive state there would store the external value instead of the driven one. It drops the enable right after driving and then changes the inputs, which exposes any output that floats or follows the inputs instead of holding. Finally it works one lane while the other lane holds different stored data, and it resets in the middle of the run, which catches crosstalk between the lanes and keeper or capture registers that survive reset.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef struct packed {
    logic oe_n;
    logic dir;
    logic sel_ab;
    logic sel_ba;
  } lane_ctl_t;

  typedef struct packed {
    logic a_en;
    logic b_en;
  } side_en_t;

  // Decode of enable and direction into per-side drive flags.
  function automatic side_en_t side_enables(input logic oe_n, input logic dir);
    side_en_t r;
    r.a_en = 1'b0;
    r.b_en = 1'b0;
    if (!oe_n) begin
      if (dir) r.b_en = 1'b1;
      else     r.a_en = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/edge_capture.sv
module edge_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         fire
);
  logic strobe_q;

  assign fire = strobe & ~strobe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      q        <= '0;
    end else begin
      strobe_q <= strobe;
      if (fire) q <= d;
    end
  end

  AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> q == $past(d)); // R7
  AST_CAPTURE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(q)); // R7
endmodule

// File: rtl/bus_keeper.sv
module bus_keeper #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         drv,
  input  logic [W-1:0] val,
  output logic [W-1:0] pin
);
  logic [W-1:0] held;
  logic         armed;

  assign pin = drv ? val : held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held  <= '0;
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (drv) held <= val;
    end
  end

  AST_KEEP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !drv) |-> pin == $past(pin)); // R10
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  lane_ctl_t    ctl,
  input  logic         cap_a,
  input  logic         cap_b,
  input  logic [W-1:0] a_ext,
  input  logic [W-1:0] b_ext,
  output logic [W-1:0] a_pin,
  output logic         a_drv,
  output logic [W-1:0] b_pin,
  output logic         b_drv
);
  side_en_t     en;
  logic [W-1:0] reg_a, reg_b;
  logic [W-1:0] a_val, b_val;
  logic [W-1:0] a_port, b_port;
  logic         fire_a, fire_b;

  assign en    = side_enables(ctl.oe_n, ctl.dir);
  assign a_drv = en.a_en;
  assign b_drv = en.b_en;

  // When one side drives, the other side is an input, so its port value is external.
  assign a_val = ctl.sel_ba ? reg_b : b_ext;
  assign b_val = ctl.sel_ab ? reg_a : a_ext;

  // Value presented for capture: own driven level or external level.
  assign a_port = a_drv ? a_val : a_ext;
  assign b_port = b_drv ? b_val : b_ext;

  edge_capture #(.W(W)) u_cap_a (
    .clk(clk), .rst_n(rst_n), .strobe(cap_a), .d(a_port), .q(reg_a), .fire(fire_a)
  );
  edge_capture #(.W(W)) u_cap_b (
    .clk(clk), .rst_n(rst_n), .strobe(cap_b), .d(b_port), .q(reg_b), .fire(fire_b)
  );

  bus_keeper #(.W(W)) u_keep_a (
    .clk(clk), .rst_n(rst_n), .drv(a_drv), .val(a_val), .pin(a_pin)
  );
  bus_keeper #(.W(W)) u_keep_b (
    .clk(clk), .rst_n(rst_n), .drv(b_drv), .val(b_val), .pin(b_pin)
  );

  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_drv && b_drv)); // R13
  AST_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.oe_n |-> (!a_drv && !b_drv)); // R2
  AST_STORED_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
    (b_drv && ctl.sel_ab && !fire_a) |=> (!b_drv || !ctl.sel_ab || b_pin == $past(b_pin))); // R6
  AST_STORED_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
    (a_drv && ctl.sel_ba && !fire_b) |=> (!a_drv || !ctl.sel_ba || a_pin == $past(a_pin))); // R4
endmodule

// File: rtl/bidir_xcvr16.sv
module bidir_xcvr16
  import xcvr_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANES  = 2,
  localparam int W = LANE_W * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] oe_n,
  input  logic [LANES-1:0] dir,
  input  logic [LANES-1:0] sel_ab,
  input  logic [LANES-1:0] sel_ba,
  input  logic [LANES-1:0] cap_a,
  input  logic [LANES-1:0] cap_b,
  input  logic [W-1:0]     a_in,
  output logic [W-1:0]     a_out,
  output logic [LANES-1:0] a_drv,
  input  logic [W-1:0]     b_in,
  output logic [W-1:0]     b_out,
  output logic [LANES-1:0] b_drv
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_ctl_t ctl;
    assign ctl = '{oe_n: oe_n[g], dir: dir[g], sel_ab: sel_ab[g], sel_ba: sel_ba[g]};

    xcvr_lane #(.W(LANE_W)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .ctl   (ctl),
      .cap_a (cap_a[g]),
      .cap_b (cap_b[g]),
      .a_ext (a_in[g*LANE_W +: LANE_W]),
      .b_ext (b_in[g*LANE_W +: LANE_W]),
      .a_pin (a_out[g*LANE_W +: LANE_W]),
      .a_drv (a_drv[g]),
      .b_pin (b_out[g*LANE_W +: LANE_W]),
      .b_drv (b_drv[g])
    );
  end
endmodule

// File: tb/sim_bidir_xcvr16.sv
module sim_bidir_xcvr16;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  oe_n = 2'b11, dir = 2'b00, sel_ab = 2'b00, sel_ba = 2'b00;
  logic [1:0]  cap_a = 2'b00, cap_b = 2'b00;
  logic [15:0] a_in = '0, b_in = '0;
  logic [15:0] a_out, b_out;
  logic [1:0]  a_drv, b_drv;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bidir_xcvr16 u0 (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .cap_a(cap_a), .cap_b(cap_b), .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
    .b_in(b_in), .b_out(b_out), .b_drv(b_drv)
  );

  // Fields: [35]oe_n [34]dir [33]sel_ab [32]sel_ba [31:24]a_in [23:16]b_in
  //         [15]expect A driven [14]expect B driven [7:0]expected driven value
  localparam logic [35:0] VEC [0:7] = '{
    36'h8_00_00_00_00, // R2 isolated
    36'h0_11_5A_80_5A, // R3 live B to A
    36'h1_11_5A_80_00, // R4 stored B (zero after reset)
    36'h4_C3_00_40_C3, // R5 live A to B
    36'h6_C3_00_40_00, // R6 stored A (zero after reset)
    36'h2_00_77_80_77, // R9 unused sel_ab set
    36'h5_3C_00_40_3C, // R9 unused sel_ba set
    36'hC_00_00_00_00  // R2 isolated with dir high
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_lane(input int l, input logic o, input logic d, input logic sab, input logic sba);
    oe_n[l] = o; dir[l] = d; sel_ab[l] = sab; sel_ba[l] = sba;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=expired expected=done");
      finish_run();
    end
  end

  initial begin : main
    step(); step();
    rst_n = 1'b1;
    #1;
    // R12 reset state: outputs show cleared keepers, nothing driven
    chk("R12 a_out", a_out, 16'h0000);
    chk("R12 b_out", b_out, 16'h0000);
    chk("R2 drv", {14'd0, a_drv, b_drv}, 16'h0000);
    step();

    // Vector table on lane 0, lane 1 left isolated
    for (int i = 0; i < 8; i++) begin
      set_lane(0, VEC[i][35], VEC[i][34], VEC[i][33], VEC[i][32]);
      a_in[7:0] = VEC[i][31:24];
      b_in[7:0] = VEC[i][23:16];
      #1;
      chk("R2/R3/R5 flags lane0", {14'd0, a_drv[0], b_drv[0]}, {14'd0, VEC[i][15], VEC[i][14]});
      if (VEC[i][15]) chk("R3/R4/R9 a_out", {8'd0, a_out[7:0]}, {8'd0, VEC[i][7:0]});
      if (VEC[i][14]) chk("R5/R6/R9 b_out", {8'd0, b_out[7:0]}, {8'd0, VEC[i][7:0]});
      chk("R1 lane1 untouched", {14'd0, a_drv[1], b_drv[1]}, 16'h0000);
      step();
    end

    // R7 R8: capture A while isolated; strobe held high must not reload
    set_lane(0, 1, 0, 0, 0);
    a_in[7:0] = 8'hA5; cap_a[0] = 1'b1;
    step();
    a_in[7:0] = 8'hFF;
    step();
    cap_a[0] = 1'b0;
    step();
    set_lane(0, 0, 1, 1, 0);
    #1;
    chk("R7/R8 stored A to B", {8'd0, b_out[7:0]}, 16'h00A5);
    step();

    // R4 R8: capture B while isolated, then send stored B to A
    set_lane(0, 1, 1, 0, 0);
    b_in[7:0] = 8'h96; cap_b[0] = 1'b1;
    step();
    cap_b[0] = 1'b0; b_in[7:0] = 8'h00;
    step();
    set_lane(0, 0, 0, 0, 1);
    #1;
    chk("R4 stored B to A", {8'd0, a_out[7:0]}, 16'h0096);

    // R11: A is driven with 96 while the external value is 01; capture must take 96
    a_in[7:0] = 8'h01; cap_a[0] = 1'b1;
    step();
    cap_a[0] = 1'b0;
    step();
    set_lane(0, 0, 1, 1, 0);
    #1;
    chk("R11 readback capture", {8'd0, b_out[7:0]}, 16'h0096);
    step();

    // R1: lane 1 captures and drives on its own
    set_lane(0, 1, 0, 0, 0);
    a_in[15:8] = 8'hE7; cap_a[1] = 1'b1;
    step();
    cap_a[1] = 1'b0;
    step();
    set_lane(1, 0, 1, 1, 0);
    #1;
    chk("R1 lane1 stored", {8'd0, b_out[15:8]}, 16'h00E7);
    chk("R1 lane0 flags", {14'd0, a_drv[0], b_drv[0]}, 16'h0000);
    step();
    set_lane(1, 1, 0, 0, 0);
    set_lane(0, 0, 1, 1, 0);
    #1;
    chk("R1 lane0 stored kept", {8'd0, b_out[7:0]}, 16'h0096);
    step();

    // R10: keeper holds last driven level after the driver turns off
    set_lane(0, 0, 1, 0, 0);
    a_in[7:0] = 8'h42;
    #1;
    chk("R5 live 42", {8'd0, b_out[7:0]}, 16'h0042);
    step();
    set_lane(0, 1, 1, 0, 0);
    a_in[7:0] = 8'h00; b_in[7:0] = 8'h3F;
    #1;
    chk("R10 hold after off", {8'd0, b_out[7:0]}, 16'h0042);
    step();
    chk("R10 hold next cycle", {8'd0, b_out[7:0]}, 16'h0042);

    // R12: reset mid-run clears keepers and stored registers
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    #1;
    chk("R12 b_out cleared", b_out, 16'h0000);
    chk("R12 a_out cleared", a_out, 16'h0000);
    set_lane(0, 0, 1, 1, 0);
    set_lane(1, 0, 0, 0, 1);
    #1;
    chk("R12 stored A cleared", {8'd0, b_out[7:0]}, 16'h0000);
    chk("R12 stored B cleared", {8'd0, a_out[15:8]}, 16'h0000);
    step();

    finish_run();
  end
endmodule